// File: doc/BRIEF.md
# DRAM Clock-Enable Power-State Sequencer

This block sits on the controller side of a DDR2-class memory interface. It owns the clock-enable pin and the command strobes whenever the memory moves into or out of a low-power mode. The memory controller raises a level request for power-down or self-refresh and holds it. The sequencer takes the request only when the device is in a legal state. It then puts CKE low together with the one command the device allows on that edge, and returns a one-cycle acknowledge.

A transition is defined by CKE at two consecutive edges. High then low enters a mode. Low then high leaves it. Low then low keeps the device where it is. Power-down becomes active or precharge power-down, depending on whether any bank is open. Self-refresh is allowed only with all banks idle. Entry is refused while an operation is in flight or calibration is running. Each CKE level is held for a minimum number of clocks. A request that arrives inside that window waits; it is not dropped.

Power-down does not refresh the array, so a down-counter forces an exit when the refresh deadline runs out. After self-refresh the block holds off all commands for a settle window and holds off reads for a longer one. Both windows are reported through ready flags.

Top module: `cke_pwr_seq`

## Requirements
- R1: After reset: cke_o=1, command {cs_no,ras_no,cas_no,we_no}=4'b0111 (NOP), state_o=0 (idle), cmd_ready_o=1, rd_ready_o=1, all acknowledges 0.
- R2: An accepted power-down request with bank_open_i=1 drives cke_o low with NOP on that edge and sets state_o=2 (active power-down).
- R3: An accepted power-down request with bank_open_i=0 drives cke_o low with NOP and sets state_o=3 (precharge power-down).
- R4: Self-refresh entry drives cke_o low with command 4'b0001 and sets state_o=4. It is refused while bank_open_i=1: no acknowledge, and cke_o stays high.
- R5: Entry is refused while op_busy_i or calib_i is high. The request stays pending and is taken on the first clock after both inputs are low.
- R6: cke_o holds each level for at least CKE_MIN cycles. An entry or exit request inside that window is delayed until the window ends.
- R7: The CKE rising edge carries NOP. Every low-power cycle after the entry edge carries deselect (cs_no=1).
- R8: After a self-refresh exit, state_o=5 for T_XSNR cycles, counted from the exit edge. During these cycles cmd_ready_o=0 and NOP is driven on every cycle.
- R9: rd_ready_o stays low for T_XSRD cycles from the self-refresh exit edge, then rises.
- R10: After a power-down exit, state_o=6 for T_XP cycles with cmd_ready_o=0. The block then returns to idle (0) or active (1).
- R11: Power-down lasts at most REF_LIMIT cycles of cke_o low. When the deadline expires the block exits on its own, with no exit acknowledge.
- R12: odt_o follows odt_en_i, except that it is forced low while state_o=4.
- R13: pd_ack_o, sr_ack_o and exit_ack_o are single-cycle pulses, at most one at a time. Each appears only on the edge where its transition is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_req_i | input | 1 | Power-down request (level) |
| sr_req_i | input | 1 | Self-refresh request (level) |
| exit_req_i | input | 1 | Request to leave the current low-power mode (level) |
| bank_open_i | input | 1 | At least one bank is open |
| op_busy_i | input | 1 | Read, write, mode-register or precharge operation in progress |
| calib_i | input | 1 | Driver calibration mode active |
| odt_en_i | input | 1 | Controller wants termination enabled |
| pd_ack_o | output | 1 | Power-down entry taken |
| sr_ack_o | output | 1 | Self-refresh entry taken |
| exit_ack_o | output | 1 | Requested exit taken |
| cke_o | output | 1 | Clock enable to the device |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| odt_o | output | 1 | Termination enable to the device |
| state_o | output | 3 | Tracked device state code |
| cmd_ready_o | output | 1 | Controller may issue commands other than NOP |
| rd_ready_o | output | 1 | Controller may issue reads |

## Verification
A wrong state register shows at the ports on the very next clock. It appears as a wrong state_o code, a wrong CKE level, or a wrong command, for example deselect where the rising edge needs NOP. A faulty hold counter or down-counter only shows at the end of a window: CKE moves one cycle early or late, or a ready flag rises too soon. So the windows are checked by counting cycles exactly at each boundary: CKE low, CKE high, the settle window, the read hold-off and the refresh deadline. Refused entries are checked on the next edge, where CKE must still be high and no acknowledge may appear.

// File: rtl/cke_pwr_pkg.sv
package cke_pwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ACT  = 3'd1,
    ST_APD  = 3'd2,
    ST_PPD  = 3'd3,
    ST_SREF = 3'd4,
    ST_XSNR = 3'd5,
    ST_PDX  = 3'd6
  } pwr_st_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_DESEL = 4'b1111;
  localparam logic [3:0] CMD_SREF  = 4'b0001;

endpackage

// File: rtl/cke_hold_timer.sv
module cke_hold_timer #(
  parameter int unsigned CKE_MIN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flip_i,
  output logic ok_o
);
  localparam int unsigned W = $clog2(CKE_MIN + 1);
  localparam logic [W-1:0] SAT = W'(CKE_MIN - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= SAT;
    else if (flip_i)    cnt_q <= '0;
    else if (cnt_q < SAT) cnt_q <= cnt_q + 1'b1;
  end

  assign ok_o = (cnt_q >= SAT);
endmodule

// File: rtl/cke_dcnt.sv
module cke_dcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         en_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= val_i;
    else if (en_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cke_pwr_seq.sv
module cke_pwr_seq
  import cke_pwr_pkg::*;
#(
  parameter int unsigned CKE_MIN   = 3,
  parameter int unsigned T_XSNR    = 10,
  parameter int unsigned T_XSRD    = 200,
  parameter int unsigned T_XP      = 2,
  parameter int unsigned REF_LIMIT = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pd_req_i,
  input  logic       sr_req_i,
  input  logic       exit_req_i,
  input  logic       bank_open_i,
  input  logic       op_busy_i,
  input  logic       calib_i,
  input  logic       odt_en_i,
  output logic       pd_ack_o,
  output logic       sr_ack_o,
  output logic       exit_ack_o,
  output logic       cke_o,
  output logic       cs_no,
  output logic       ras_no,
  output logic       cas_no,
  output logic       we_no,
  output logic       odt_o,
  output logic [2:0] state_o,
  output logic       cmd_ready_o,
  output logic       rd_ready_o
);
  localparam int unsigned WAIT_MAX = (T_XSNR > T_XP) ? T_XSNR : T_XP;
  localparam int unsigned REF_W    = $clog2(REF_LIMIT + 1);
  localparam int unsigned WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int unsigned RD_W     = $clog2(T_XSRD + 1);

  pwr_st_e    state_q, state_d;
  logic       cke_q, cke_d;
  logic [3:0] cmd_q, cmd_d;
  logic       pd_ack_q, pd_ack_d, sr_ack_q, sr_ack_d, ex_ack_q, ex_ack_d;
  logic       flip, hold_ok, entry_ok, low_st, awake;
  logic       ref_load, ref_zero, wait_load, wait_zero, rd_load, rd_zero;
  logic [WAIT_W-1:0] wait_val;
  pwr_st_e    wake_st;

  cke_hold_timer #(.CKE_MIN(CKE_MIN)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .flip_i(flip), .ok_o(hold_ok)
  );

  // refresh deadline inside power-down
  cke_dcnt #(.W(REF_W)) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ref_load),
    .val_i(REF_W'(REF_LIMIT - 1)),
    .en_i(state_q == ST_APD || state_q == ST_PPD), .zero_o(ref_zero)
  );

  // exit settle window (self-refresh or power-down)
  cke_dcnt #(.W(WAIT_W)) u_wait (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(wait_load), .val_i(wait_val),
    .en_i(state_q == ST_XSNR || state_q == ST_PDX), .zero_o(wait_zero)
  );

  // read hold-off after self-refresh
  cke_dcnt #(.W(RD_W)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(rd_load),
    .val_i(RD_W'(T_XSRD)), .en_i(1'b1), .zero_o(rd_zero)
  );

  assign low_st   = (state_q == ST_APD) || (state_q == ST_PPD) || (state_q == ST_SREF);
  assign awake    = (state_q == ST_IDLE) || (state_q == ST_ACT);
  assign entry_ok = hold_ok && !op_busy_i && !calib_i;
  assign wake_st  = bank_open_i ? ST_ACT : ST_IDLE;

  always_comb begin
    state_d   = state_q;
    cke_d     = cke_q;
    cmd_d     = low_st ? CMD_DESEL : CMD_NOP;
    pd_ack_d  = 1'b0;
    sr_ack_d  = 1'b0;
    ex_ack_d  = 1'b0;
    flip      = 1'b0;
    ref_load  = 1'b0;
    wait_load = 1'b0;
    rd_load   = 1'b0;
    wait_val  = WAIT_W'(T_XP - 1);
    unique case (state_q)
      ST_IDLE, ST_ACT: begin
        state_d = wake_st;
        if (entry_ok && sr_req_i && !bank_open_i) begin
          state_d  = ST_SREF;
          cke_d    = 1'b0;
          cmd_d    = CMD_SREF;
          sr_ack_d = 1'b1;
          flip     = 1'b1;
        end else if (entry_ok && pd_req_i) begin
          state_d  = bank_open_i ? ST_APD : ST_PPD;
          cke_d    = 1'b0;
          cmd_d    = CMD_NOP;
          pd_ack_d = 1'b1;
          flip     = 1'b1;
          ref_load = 1'b1;
        end
      end
      ST_APD, ST_PPD: begin
        if (hold_ok && (exit_req_i || ref_zero)) begin
          state_d   = ST_PDX;
          cke_d     = 1'b1;
          cmd_d     = CMD_NOP;
          ex_ack_d  = exit_req_i;
          flip      = 1'b1;
          wait_load = 1'b1;
        end
      end
      ST_SREF: begin
        if (hold_ok && exit_req_i) begin
          state_d   = ST_XSNR;
          cke_d     = 1'b1;
          cmd_d     = CMD_NOP;
          ex_ack_d  = 1'b1;
          flip      = 1'b1;
          wait_load = 1'b1;
          wait_val  = WAIT_W'(T_XSNR - 1);
          rd_load   = 1'b1;
        end
      end
      ST_XSNR, ST_PDX: begin
        if (wait_zero) state_d = wake_st;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cke_q    <= 1'b1;
      cmd_q    <= CMD_NOP;
      pd_ack_q <= 1'b0;
      sr_ack_q <= 1'b0;
      ex_ack_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cke_q    <= cke_d;
      cmd_q    <= cmd_d;
      pd_ack_q <= pd_ack_d;
      sr_ack_q <= sr_ack_d;
      ex_ack_q <= ex_ack_d;
    end
  end

  assign cke_o       = cke_q;
  assign {cs_no, ras_no, cas_no, we_no} = cmd_q;
  assign pd_ack_o    = pd_ack_q;
  assign sr_ack_o    = sr_ack_q;
  assign exit_ack_o  = ex_ack_q;
  assign state_o     = state_q;
  assign odt_o       = odt_en_i && (state_q != ST_SREF);
  assign cmd_ready_o = awake;
  assign rd_ready_o  = awake && rd_zero;
endmodule

// File: rtl/cke_pwr_seq_chk.sv
module cke_pwr_seq_chk
  import cke_pwr_pkg::*;
#(
  parameter int unsigned CKE_MIN = 3
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bank_open_i,
  input logic       op_busy_i,
  input logic       calib_i,
  input logic       pd_ack_o,
  input logic       sr_ack_o,
  input logic       exit_ack_o,
  input logic       cke_o,
  input logic       cs_no,
  input logic       ras_no,
  input logic       cas_no,
  input logic       we_no,
  input logic       odt_o,
  input logic [2:0] state_o,
  input logic       cmd_ready_o,
  input logic       rd_ready_o
);
  localparam int unsigned W = $clog2(CKE_MIN + 1);
  localparam logic [W-1:0] SAT = W'(CKE_MIN - 1);

  logic         cke_prev;
  logic [W-1:0] lvl_cnt;
  logic [3:0]   cmd;

  assign cmd = {cs_no, ras_no, cas_no, we_no};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_prev <= 1'b1;
      lvl_cnt  <= SAT;
    end else begin
      cke_prev <= cke_o;
      if (cke_o != cke_prev)  lvl_cnt <= '0;
      else if (lvl_cnt < SAT) lvl_cnt <= lvl_cnt + 1'b1;
    end
  end

  p_cke_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_o != cke_prev) |-> (lvl_cnt == SAT));

  p_sref_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_o && cmd == CMD_SREF) |-> (state_o == ST_SREF && $past(!bank_open_i)));

  p_busy_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> $past(!op_busy_i && !calib_i));

  p_exit_nop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (cmd == CMD_NOP));

  p_xsnr_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_XSNR) |-> (cmd == CMD_NOP && !cmd_ready_o));

  p_rd_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ready_o |-> cmd_ready_o);

  p_odt_off_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_SREF) |-> !odt_o);

  p_ack_excl_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pd_ack_o, sr_ack_o, exit_ack_o}));

  p_ack_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_ack_o || sr_ack_o || exit_ack_o) |=> !(pd_ack_o || sr_ack_o || exit_ack_o));
endmodule

bind cke_pwr_seq cke_pwr_seq_chk #(.CKE_MIN(CKE_MIN)) u_chk (.*);

// File: tb/cke_pwr_seq_tb_top.sv
module cke_pwr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CKE_MIN = 3, T_XSNR = 8, T_XSRD = 40, T_XP = 1, REF_LIMIT = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pd_req = 0, sr_req = 0, exit_req = 0, bank = 0, busy = 0, calib = 0, odt_en = 0;
  logic pd_ack, sr_ack, ex_ack, cke, cs_n, ras_n, cas_n, we_n, odt, cmd_rdy, rd_rdy;
  logic [2:0] st;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cke_pwr_seq #(.CKE_MIN(CKE_MIN), .T_XSNR(T_XSNR), .T_XSRD(T_XSRD),
                .T_XP(T_XP), .REF_LIMIT(REF_LIMIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pd_req_i(pd_req), .sr_req_i(sr_req),
    .exit_req_i(exit_req), .bank_open_i(bank), .op_busy_i(busy), .calib_i(calib),
    .odt_en_i(odt_en), .pd_ack_o(pd_ack), .sr_ack_o(sr_ack), .exit_ack_o(ex_ack),
    .cke_o(cke), .cs_no(cs_n), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n),
    .odt_o(odt), .state_o(st), .cmd_ready_o(cmd_rdy), .rd_ready_o(rd_rdy));

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cmd4();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic leave_low();
    exit_req = 1;
    for (int i = 0; i < 40 && !ex_ack; i++) @(negedge clk);
    exit_req = 0;
    for (int i = 0; i < 80 && !cmd_rdy; i++) @(negedge clk);
  endtask

  // {bank, busy, calib, use_sr, taken, exp_state[2:0]}
  localparam logic [7:0] VEC [6] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2},  // R2
    {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3},  // R3
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd4},  // R4
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1},  // R4 refused
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0},  // R5 busy
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0}   // R5 calib
  };

  initial begin
    repeat (50000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int cnt, ack_seen, nrdy, rdlow;
    step(2);
    rst_n = 1;
    step(1);
    check("R1 cke", cke, 1);
    check("R1 cmd", cmd4(), 'b0111);
    check("R1 state", st, 0);
    check("R1 cmd_ready", cmd_rdy, 1);
    check("R1 rd_ready", rd_rdy, 1);
    check("R1 acks", {pd_ack, sr_ack, ex_ack}, 0);

    foreach (VEC[i]) begin
      bank = VEC[i][7]; busy = VEC[i][6]; calib = VEC[i][5];
      step(4);
      if (VEC[i][4]) sr_req = 1; else pd_req = 1;
      step(1);
      check($sformatf("R2/R3/R4/R5 vec%0d state", i), st, VEC[i][2:0]);
      check($sformatf("R2/R3/R4/R5 vec%0d cke", i), cke, !VEC[i][3]);
      check($sformatf("R13 vec%0d ack", i), VEC[i][4] ? sr_ack : pd_ack, VEC[i][3]);
      if (VEC[i][3]) check($sformatf("R4 vec%0d entry cmd", i), cmd4(), VEC[i][4] ? 'b0001 : 'b0111);
      pd_req = 0; sr_req = 0; busy = 0; calib = 0;
      if (VEC[i][3]) begin
        step(3);
        leave_low();
      end
    end
    bank = 0;
    step(4);

    // R6/R7/R10: immediate exit request after entry, immediate re-entry
    pd_req = 1;
    step(1);
    check("R3 pd ack", pd_ack, 1);
    pd_req = 0; exit_req = 1;
    cnt = 0;
    while (!cke && cnt < 20) begin
      if (cnt == 1) check("R7 deselect in pd", cs_n, 1);
      cnt++; step(1);
    end
    check("R6 cke low hold", cnt, CKE_MIN);
    check("R7 exit cmd", cmd4(), 'b0111);
    check("R13 exit ack", ex_ack, 1);
    exit_req = 0; pd_req = 1;
    cnt = 0;
    while (cke && cnt < 20) begin
      if (cnt == 0) check("R10 pdx state", st, 6);
      if (cnt == 0) check("R10 pdx not ready", cmd_rdy, 0);
      if (cnt == 1) check("R10 back idle", st, 0);
      cnt++; step(1);
    end
    check("R6 cke high hold", cnt, CKE_MIN);
    check("R6 stalled pd ack", pd_ack, 1);
    pd_req = 0;

    // R11: refresh deadline forces exit
    cnt = 0; ack_seen = 0;
    while (!cke && cnt < 100) begin
      if (ex_ack) ack_seen++;
      cnt++; step(1);
    end
    check("R11 pd length", cnt, REF_LIMIT);
    check("R11 no exit ack", ack_seen + ex_ack, 0);
    step(4);

    // R5: stalled while busy
    busy = 1; pd_req = 1;
    ack_seen = 0;
    for (int i = 0; i < 5; i++) begin step(1); ack_seen += pd_ack; end
    check("R5 busy no ack", ack_seen, 0);
    check("R5 busy cke high", cke, 1);
    busy = 0;
    step(1);
    check("R5 taken after busy", pd_ack, 1);
    pd_req = 0;
    step(3);
    leave_low();
    step(4);

    // R12/R8/R9: self-refresh with termination
    odt_en = 1;
    step(1);
    check("R12 odt awake", odt, 1);
    sr_req = 1;
    step(1);
    check("R4 sref cmd", cmd4(), 'b0001);
    check("R12 odt off in sref", odt, 0);
    sr_req = 0;
    step(1);
    check("R7 deselect in sref", cs_n, 1);
    step(3);
    exit_req = 1;
    for (int i = 0; i < 20 && !ex_ack; i++) step(1);
    check("R8 exit ack", ex_ack, 1);
    check("R12 odt back", odt, 1);
    exit_req = 0;
    nrdy = 0; rdlow = 0;
    for (int i = 0; i < T_XSRD + 20; i++) begin
      if (!cmd_rdy) begin
        nrdy++;
        if (cmd4() != 'b0111) check("R8 nop in window", cmd4(), 'b0111);
      end
      if (!rd_rdy) rdlow++;
      step(1);
    end
    check("R8 settle length", nrdy, T_XSNR);
    check("R9 read holdoff", rdlow, T_XSRD);
    check("R9 rd ready end", rd_rdy, 1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule